// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels, numbered 0 and 1. Each channel is stored as a low byte and a high byte. A four-bit configuration nibble per channel selects one of four counting modes, a gate option and the source of increments. Increments come either from a machine-cycle strobe (`tick`) or, in counter mode, from falling edges on an external count pin. The count pin is sampled once per machine cycle. Each channel has a run bit and an overflow flag, and the flags drive the interrupt request outputs.

Software reaches the byte registers, the run bits, the flags and the configuration byte through a simple register port. Writes take effect at the next clock edge. Reads are combinational. An interrupt controller outside the block pulses `irq_ack` to clear a serviced flag.

Two small state machines control the block. The count-pin sampler in each channel has two states, PIN_LOW and PIN_HIGH. On every tick it moves to the state that matches the sampled pin level. The transition from PIN_HIGH to PIN_LOW is the one that produces an increment. The flag keeper in each channel also has two states, FLG_CLEAR and FLG_PENDING:
- It goes from FLG_CLEAR to FLG_PENDING on a hardware overflow, or on a software write of 1 with no acknowledge.
- It goes from FLG_PENDING to FLG_CLEAR on an acknowledge or a software write of 0, unless an overflow happens in the same cycle.

Top module: `dual_timer`

## Requirements
- R1: After reset, all four count bytes, the control byte and the configuration byte read 0, and `irq` is 0.
- R2: The register port uses these addresses: 0 = channel-0 low byte, 1 = channel-1 low byte, 2 = channel-0 high byte, 3 = channel-1 high byte, 4 = control, 5 = configuration. Writes are seen on `rd_data` from the next cycle. Control bits are: bit7 = flag 1, bit6 = run 1, bit5 = flag 0, bit4 = run 0; bits 3:0 read 0. Configuration bits [3:0] belong to channel 0 and bits [7:4] to channel 1. Within each nibble, bit 3 = gate, bit 2 = count-pin source, and bits 1:0 = mode.
- R3: Mode 00 counts 13 bits, with the high byte as the upper 8 bits and low-byte bits 4:0 as the lower 5. Low-byte bits 7:5 are held at 0, including on software writes. A count of 0x1FFF wraps to 0 and sets the channel's flag.
- R4: Mode 01 counts 16 bits across the high:low pair. A count of 0xFFFF wraps to 0 and sets the flag.
- R5: Mode 10 counts in the low byte only. When the low byte overflows from 0xFF, it is loaded from the high byte and the flag is set. The high byte does not change.
- R6: Mode 11 on channel 1 halts it: neither byte of channel 1 changes except through software writes.
- R7: Mode 11 on channel 0 splits it into two 8-bit counters. The low byte is enabled by run 0 and gate 0 and sets flag 0. The high byte counts ticks while run 1 is set and sets flag 1. While channel 0 is split, channel 1 keeps counting but its overflow does not set flag 1.
- R8: A channel whose run bit is 0 does not count.
- R9: With the gate bit set, a channel counts only while its `gate_pin` is high. With the gate bit clear, the run bit alone enables counting.
- R10: In counter mode, a channel counts once for each tick on which its count pin reads 0 after reading 1 on the previous tick. Pin changes between ticks are not seen.
- R11: `irq[i]` equals flag i. A flag is cleared by `irq_ack[i]` or by a control write of 0 to its bit. A control write of 1 sets it. An acknowledge takes priority over a write of 1.
- R12: A hardware overflow in the same cycle as a clearing write or an acknowledge leaves the flag set.
- R13: Count bytes change only on cycles with `tick` high, or through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate inputs, one per channel |
| irq_ack | input | 2 | Interrupt-serviced strobes, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 2 | Overflow flags as interrupt requests |

## Verification
The bench targets these corner cases:
- **Wrap of the 13-bit count.** A design that lets low-byte bits 7:5 take part in the count would carry into the high byte at the wrong point and miss 0x1FFF.
- **Split mode.** The bench checks that the high byte borrows run 1 and flag 1, and that channel 1's own overflow is then kept away from flag 1. A design that leaves channel 1 connected to flag 1 raises a spurious request.
- **Same-cycle overflow and clear.** An overflow that arrives together with a clearing write must leave the flag set. If the write wins, the interrupt is lost.
- **Pin edges between ticks.** The bench checks that edges between ticks produce no count. A design that samples every clock would count such edges.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } chcfg_t;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PRE_W   = 5;
    localparam int unsigned WIDE_W  = 2 * BYTE_W;
    localparam int unsigned NARROW_W = BYTE_W + PRE_W;
    localparam int unsigned CFG_W   = 4;

    localparam int unsigned A_LO_BASE = 0;
    localparam int unsigned A_HI_BASE = 2;
    localparam int unsigned A_CTRL    = 4;
    localparam int unsigned A_CFG     = 5;

    localparam int unsigned RUN_BIT0  = 4;
    localparam int unsigned FLAG_BIT0 = 5;

endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    typedef enum logic {PIN_LOW = 1'b0, PIN_HIGH = 1'b1} pin_st_e;

    pin_st_e state_q;
    pin_st_e state_n;

    always_comb begin
        state_n = state_q;
        if (tick) begin
            state_n = pin ? PIN_HIGH : PIN_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            PIN_HIGH: fall = tick & ~pin;
            PIN_LOW:  fall = 1'b0;
        endcase
    end

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter bit CAN_SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmode_e            mode,
    input  logic              inc_a,
    input  logic              inc_b,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] tl,
    output logic [BYTE_W-1:0] th,
    output logic              ovf_a,
    output logic              ovf_b
);
    logic [BYTE_W-1:0]   tl_q, th_q, tl_n, th_n;
    logic [NARROW_W-1:0] cnt13;
    logic [WIDE_W-1:0]   cnt16;

    assign cnt13 = {th_q, tl_q[PRE_W-1:0]} + NARROW_W'(1);
    assign cnt16 = {th_q, tl_q} + WIDE_W'(1);

    always_comb begin
        tl_n  = tl_q;
        th_n  = th_q;
        ovf_a = 1'b0;
        ovf_b = 1'b0;
        unique case (mode)
            MODE_13: begin
                if (inc_a) begin
                    th_n  = cnt13[NARROW_W-1:PRE_W];
                    tl_n  = {{(BYTE_W-PRE_W){1'b0}}, cnt13[PRE_W-1:0]};
                    ovf_a = &{th_q, tl_q[PRE_W-1:0]};
                end
                tl_n[BYTE_W-1:PRE_W] = '0;
            end
            MODE_16: begin
                if (inc_a) begin
                    {th_n, tl_n} = cnt16;
                    ovf_a        = &{th_q, tl_q};
                end
            end
            MODE_RELOAD: begin
                if (inc_a) begin
                    if (&tl_q) begin
                        tl_n  = th_q;
                        ovf_a = 1'b1;
                    end else begin
                        tl_n = tl_q + BYTE_W'(1);
                    end
                end
            end
            MODE_SPLIT: begin
                if (CAN_SPLIT) begin
                    if (inc_a) begin
                        tl_n  = tl_q + BYTE_W'(1);
                        ovf_a = &tl_q;
                    end
                    if (inc_b) begin
                        th_n  = th_q + BYTE_W'(1);
                        ovf_b = &th_q;
                    end
                end
            end
        endcase
        if (wr_lo) begin
            tl_n = (mode == MODE_13) ? {{(BYTE_W-PRE_W){1'b0}}, wr_data[PRE_W-1:0]} : wr_data;
        end
        if (wr_hi) begin
            th_n = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tl_q <= '0;
            th_q <= '0;
        end else begin
            tl_q <= tl_n;
            th_q <= th_n;
        end
    end

    assign tl = tl_q;
    assign th = th_q;

    assert_prescale_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_13 |=> tl_q[BYTE_W-1:PRE_W] == '0);

    assert_wide_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_16 && inc_a && !wr_lo && !wr_hi) |=> {th_q, tl_q} == $past({th_q, tl_q}) + WIDE_W'(1));

    assert_reload_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && inc_a && (&tl_q) && !wr_lo && !wr_hi) |=> (tl_q == $past(th_q)) && $stable(th_q));

    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!CAN_SPLIT && mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> $stable(tl_q) && $stable(th_q));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_a && !inc_b && !wr_lo && !wr_hi && mode != MODE_13) |=> $stable(tl_q) && $stable(th_q));

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        irq_ack,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [1:0]        irq
);
    localparam int unsigned NCH = 2;

    typedef enum logic {FLG_CLEAR = 1'b0, FLG_PENDING = 1'b1} flg_e;

    logic [BYTE_W-1:0] cfg_q;
    logic [NCH-1:0]    run_q;
    logic              ctrl_wr, cfg_wr;
    logic              split0;

    chcfg_t            cfg      [NCH];
    logic [BYTE_W-1:0] tl       [NCH];
    logic [BYTE_W-1:0] th       [NCH];
    logic [NCH-1:0]    fall, inc_a, inc_b, ovf_a, ovf_b, wr_lo, wr_hi;
    logic [NCH-1:0]    set_flag, flag;

    assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
    assign cfg_wr  = wr_en && (addr == ADDR_W'(A_CFG));
    assign split0  = (cfg[0].mode == MODE_SPLIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= '0;
        end else begin
            if (cfg_wr) begin
                cfg_q <= wr_data;
            end
            if (ctrl_wr) begin
                run_q <= {wr_data[RUN_BIT0+2], wr_data[RUN_BIT0]};
            end
        end
    end

    assign set_flag[0] = ovf_a[0];
    assign set_flag[1] = split0 ? ovf_b[0] : (ovf_a[1] | ovf_b[1]);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int unsigned RB = RUN_BIT0 + 2 * i;
        localparam int unsigned FB = FLAG_BIT0 + 2 * i;

        logic en;
        logic src;
        flg_e flg_q, flg_n;

        assign cfg[i] = chcfg_t'(cfg_q[CFG_W*i +: CFG_W]);
        assign wr_lo[i] = wr_en && (addr == ADDR_W'(A_LO_BASE + i));
        assign wr_hi[i] = wr_en && (addr == ADDR_W'(A_HI_BASE + i));

        dtmr_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .pin  (cnt_pin[i]),
            .fall (fall[i])
        );

        assign en       = run_q[i] && (!cfg[i].gate || gate_pin[i]);
        assign src      = cfg[i].ext ? fall[i] : tick;
        assign inc_a[i] = en && src;
        if (i == 0) begin : g_borrow
            assign inc_b[i] = tick && run_q[1];
        end else begin : g_noborrow
            assign inc_b[i] = 1'b0;
        end

        dtmr_chan #(.CAN_SPLIT(i == 0)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (cfg[i].mode),
            .inc_a  (inc_a[i]),
            .inc_b  (inc_b[i]),
            .wr_lo  (wr_lo[i]),
            .wr_hi  (wr_hi[i]),
            .wr_data(wr_data),
            .tl     (tl[i]),
            .th     (th[i]),
            .ovf_a  (ovf_a[i]),
            .ovf_b  (ovf_b[i])
        );

        always_comb begin
            flg_n = flg_q;
            unique case (flg_q)
                FLG_CLEAR: begin
                    if (set_flag[i] || (ctrl_wr && wr_data[FB] && !irq_ack[i])) begin
                        flg_n = FLG_PENDING;
                    end
                end
                FLG_PENDING: begin
                    if (!set_flag[i] && (irq_ack[i] || (ctrl_wr && !wr_data[FB]))) begin
                        flg_n = FLG_CLEAR;
                    end
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flg_q <= FLG_CLEAR;
            end else begin
                flg_q <= flg_n;
            end
        end

        assign flag[i] = (flg_q == FLG_PENDING);

        assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            set_flag[i] |=> irq[i]);

        assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[i] && !set_flag[i]) |=> !irq[i]);

        assert_no_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !wr_en && $stable(cfg_q)) |=> $stable(tl[i]) && $stable(th[i]));

        wire unused_rb = wr_data[RB];
    end

    assign irq = flag;

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(A_LO_BASE)) begin
            rd_data = tl[0];
        end else if (addr == ADDR_W'(A_LO_BASE + 1)) begin
            rd_data = tl[1];
        end else if (addr == ADDR_W'(A_HI_BASE)) begin
            rd_data = th[0];
        end else if (addr == ADDR_W'(A_HI_BASE + 1)) begin
            rd_data = th[1];
        end else if (addr == ADDR_W'(A_CTRL)) begin
            rd_data = {flag[1], run_q[1], flag[0], run_q[0], 4'b0000};
        end else if (addr == ADDR_W'(A_CFG)) begin
            rd_data = cfg_q;
        end
    end

endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] irq;

    int n_checks = 0;
    int n_err = 0;

    logic [7:0] m_tl [2];
    logic [7:0] m_th [2];
    logic [7:0] m_cfg;
    logic [1:0] m_run, m_flag, m_smp;

    dual_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic void adv(input logic [1:0] md, input bit split_ok, input bit ia, input bit ib,
                                inout logic [7:0] lo, inout logic [7:0] hi,
                                output bit oa, output bit ob);
        logic [12:0] v13;
        logic [15:0] v16;
        oa = 1'b0;
        ob = 1'b0;
        case (md)
            2'b00: begin
                if (ia) begin
                    v13 = {hi, lo[4:0]};
                    oa  = (v13 == 13'h1FFF);
                    v13 = v13 + 13'd1;
                    hi  = v13[12:5];
                    lo  = {3'b000, v13[4:0]};
                end
                lo[7:5] = 3'b000;
            end
            2'b01: begin
                if (ia) begin
                    v16 = {hi, lo};
                    oa  = (v16 == 16'hFFFF);
                    v16 = v16 + 16'd1;
                    {hi, lo} = v16;
                end
            end
            2'b10: begin
                if (ia) begin
                    if (lo == 8'hFF) begin
                        lo = hi;
                        oa = 1'b1;
                    end else begin
                        lo = lo + 8'd1;
                    end
                end
            end
            default: begin
                if (split_ok) begin
                    if (ia) begin
                        oa = (lo == 8'hFF);
                        lo = lo + 8'd1;
                    end
                    if (ib) begin
                        ob = (hi == 8'hFF);
                        hi = hi + 8'd1;
                    end
                end
            end
        endcase
    endfunction

    function automatic logic [7:0] model_reg(input logic [2:0] a);
        case (a)
            3'd0: return m_tl[0];
            3'd1: return m_tl[1];
            3'd2: return m_th[0];
            3'd3: return m_th[1];
            3'd4: return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'b0000};
            3'd5: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic step();
        bit ia [2];
        bit oa0, ob0, oa1, ob1;
        bit s [2];
        bit base;
        for (int i = 0; i < 2; i++) begin
            bit gt, ct, fl;
            gt = m_cfg[4*i+3];
            ct = m_cfg[4*i+2];
            fl = tick && m_smp[i] && !cnt_pin[i];
            ia[i] = m_run[i] && (!gt || gate_pin[i]) && (ct ? fl : tick);
        end
        adv(m_cfg[1:0], 1'b1, ia[0], tick && m_run[1], m_tl[0], m_th[0], oa0, ob0);
        adv(m_cfg[5:4], 1'b0, ia[1], 1'b0, m_tl[1], m_th[1], oa1, ob1);
        s[0] = oa0;
        s[1] = (m_cfg[1:0] == 2'b11) ? ob0 : (oa1 | ob1);
        for (int i = 0; i < 2; i++) begin
            base = (wr_en && addr == 3'd4) ? wr_data[5+2*i] : m_flag[i];
            if (irq_ack[i]) base = 1'b0;
            m_flag[i] = s[i] | base;
        end
        if (wr_en) begin
            case (addr)
                3'd0: m_tl[0] = (m_cfg[1:0] == 2'b00) ? {3'b000, wr_data[4:0]} : wr_data;
                3'd1: m_tl[1] = (m_cfg[5:4] == 2'b00) ? {3'b000, wr_data[4:0]} : wr_data;
                3'd2: m_th[0] = wr_data;
                3'd3: m_th[1] = wr_data;
                3'd4: m_run = {wr_data[6], wr_data[4]};
                3'd5: m_cfg = wr_data;
                default: ;
            endcase
        end
        if (tick) m_smp = cnt_pin;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a;
        wr_data = d;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        wr_en = 1'b0;
        addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int k = 0; k < n; k++) step();
        tick = 1'b0;
    endtask

    initial begin
        logic [7:0] v0, v1;
        m_tl[0] = 0; m_tl[1] = 0; m_th[0] = 0; m_th[1] = 0;
        m_cfg = 0; m_run = 0; m_flag = 0; m_smp = 0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset register");
        chk("R1 reset irq", {6'b0, irq}, 8'h00);

        // R2 register map
        wr(3'd5, 8'h11);
        wr(3'd0, 8'h5A); wr(3'd2, 8'hC3); wr(3'd1, 8'h3C); wr(3'd3, 8'hA5);
        rd_chk(3'd0, 8'h5A, "R2 lo0"); rd_chk(3'd2, 8'hC3, "R2 hi0");
        rd_chk(3'd1, 8'h3C, "R2 lo1"); rd_chk(3'd3, 8'hA5, "R2 hi1");
        rd_chk(3'd5, 8'h11, "R2 cfg");
        wr(3'd4, 8'h5F);
        rd_chk(3'd4, 8'h50, "R2 ctrl low nibble reads 0");

        // R13 no tick, no count
        repeat (3) step();
        rd_chk(3'd0, 8'h5A, "R13 no tick");

        // R4 16-bit step and wrap
        wr(3'd1, 8'hFF); wr(3'd3, 8'h12);
        ticks(1);
        rd_chk(3'd1, 8'h00, "R4 lo carry"); rd_chk(3'd3, 8'h13, "R4 hi carry");
        rd_chk(3'd0, 8'h5B, "R4 ch0 step");
        wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
        ticks(1);
        rd_chk(3'd3, 8'h00, "R4 wrap hi");
        chk("R4 wrap sets flag1", {6'b0, irq}, 8'h02);

        // R11 ack and software clear/set
        irq_ack = 2'b10; step(); irq_ack = 2'b00;
        chk("R11 ack clears", {6'b0, irq}, 8'h00);
        wr(3'd4, 8'hD0);
        chk("R11 write sets", {6'b0, irq}, 8'h02);
        wr(3'd4, 8'h50);
        chk("R11 write clears", {6'b0, irq}, 8'h00);

        // R12 overflow beats clearing write
        wr(3'd3, 8'hFF); wr(3'd1, 8'hFF);
        tick = 1'b1; wr(3'd4, 8'h50); tick = 1'b0;
        chk("R12 set wins", {6'b0, irq}, 8'h02);

        // R8 run off
        wr(3'd4, 8'h00);
        addr = 3'd0; #1; v0 = rd_data;
        addr = 3'd1; #1; v1 = rd_data;
        ticks(3);
        rd_chk(3'd0, v0, "R8 ch0 stopped"); rd_chk(3'd1, v1, "R8 ch1 stopped");

        // R3 13-bit
        wr(3'd5, 8'h10);
        wr(3'd0, 8'hFE);
        rd_chk(3'd0, 8'h1E, "R3 write mask");
        wr(3'd2, 8'hFF); wr(3'd4, 8'h10);
        ticks(1);
        rd_chk(3'd0, 8'h1F, "R3 step");
        ticks(1);
        rd_chk(3'd0, 8'h00, "R3 wrap lo"); rd_chk(3'd2, 8'h00, "R3 wrap hi");
        chk("R3 wrap flag0", {6'b0, irq}, 8'h01);
        wr(3'd4, 8'h00);

        // R5 reload
        wr(3'd5, 8'h12); wr(3'd2, 8'hF0); wr(3'd0, 8'hFE); wr(3'd4, 8'h10);
        ticks(1);
        rd_chk(3'd0, 8'hFF, "R5 step");
        ticks(1);
        rd_chk(3'd0, 8'hF0, "R5 reload"); rd_chk(3'd2, 8'hF0, "R5 hi kept");
        chk("R5 flag0", {6'b0, irq}, 8'h01);
        wr(3'd4, 8'h00);

        // R6 channel 1 halted
        wr(3'd5, 8'h32); wr(3'd1, 8'h40); wr(3'd3, 8'h41); wr(3'd4, 8'h40);
        ticks(4);
        rd_chk(3'd1, 8'h40, "R6 lo1 held"); rd_chk(3'd3, 8'h41, "R6 hi1 held");

        // R7 split
        wr(3'd5, 8'h13); wr(3'd0, 8'hFE); wr(3'd2, 8'h10); wr(3'd4, 8'h10);
        ticks(2);
        rd_chk(3'd0, 8'h00, "R7 low wrap"); rd_chk(3'd2, 8'h10, "R7 high waits run1");
        chk("R7 flag0 from low", {6'b0, irq}, 8'h01);
        wr(3'd4, 8'h40);
        ticks(1);
        rd_chk(3'd2, 8'h11, "R7 high on run1"); rd_chk(3'd0, 8'h00, "R7 low waits run0");
        rd_chk(3'd1, 8'h41, "R7 ch1 counts");
        wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
        ticks(1);
        rd_chk(3'd3, 8'h00, "R7 ch1 wrapped");
        chk("R7 ch1 wrap no flag", {6'b0, irq}, 8'h00);
        wr(3'd2, 8'hFF);
        ticks(1);
        rd_chk(3'd2, 8'h00, "R7 high wrap");
        chk("R7 flag1 from high", {6'b0, irq}, 8'h02);
        wr(3'd4, 8'h00);

        // R9 gate
        wr(3'd5, 8'h09); wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h10);
        gate_pin = 2'b00; ticks(3);
        rd_chk(3'd0, 8'h00, "R9 gate low");
        gate_pin = 2'b01; ticks(3);
        rd_chk(3'd0, 8'h03, "R9 gate high");
        gate_pin = 2'b00; wr(3'd4, 8'h00);

        // R10 count pin
        wr(3'd5, 8'h05); wr(3'd0, 8'h00); wr(3'd4, 8'h10);
        cnt_pin = 2'b01; ticks(2);
        rd_chk(3'd0, 8'h00, "R10 no fall");
        cnt_pin = 2'b00; ticks(1);
        rd_chk(3'd0, 8'h01, "R10 fall counts");
        ticks(1);
        rd_chk(3'd0, 8'h01, "R10 low level no count");
        cnt_pin = 2'b01; step(); cnt_pin = 2'b00; step();
        ticks(1);
        rd_chk(3'd0, 8'h01, "R10 edge between ticks");
        cnt_pin = 2'b01; ticks(1); cnt_pin = 2'b00; ticks(1);
        rd_chk(3'd0, 8'h02, "R10 second fall");

        // random phase against bench model
        for (int n = 0; n < 4000; n++) begin
            tick     = 1'($urandom % 2);
            cnt_pin  = 2'($urandom);
            gate_pin = 2'($urandom);
            irq_ack  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            wr_en    = (($urandom % 6) == 0);
            addr     = 3'($urandom % 6);
            wr_data  = 8'($urandom);
            step();
            wr_en = 1'b0; irq_ack = 2'b00;
            chk("R11 random irq", {6'b0, irq}, {6'b0, m_flag});
            begin
                logic [2:0] ra;
                ra = 3'($urandom % 6);
                rd_chk(ra, model_reg(ra), "R2 random readback");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule